// File: doc/BRIEF.md
# DDR Refresh Sequencer with Chip-Select Staggering

This block schedules refresh for a DDR SDRAM controller that drives several chip selects (two by default). An interval down-counter adds one owed refresh per programmed period. The owed count can build up to a programmed posting limit. When refresh is due, the block asks the main command arbiter for the bus. Once the grant is sampled, it drives a precharge-all to each chip select in turn, then an auto-refresh to each chip select in turn. No two chip selects receive a command on the same cycle, which spreads the current draw.

After the last auto-refresh, a busy flag keeps new traffic off the bus for a recovery time. That time is the sum of a base count and an extension count. Busy is high from the first command through the end of recovery.

In sleep, a self-refresh enable selects one of two modes:
- Self-refresh: staggered precharges, then one refresh sent to all chip selects together with clock enable low. Clock enable stays low until sleep is released, and a programmable exit delay follows.
- No refresh: the block issues nothing and asks for nothing.

Configuration inputs are captured only while the sequencer is idle.

Top module: `dram_refresh_sched`

## Requirements
- R1: The cycle after the edge at which `refReq` and `refGnt` are both sampled high, four commands appear on four consecutive cycles, in this order: precharge-all to chip select 0, precharge-all to chip select 1, auto-refresh to chip select 0, auto-refresh to chip select 1. Commands are active low. Precharge-all is RAS, WE and the selected CS low, with CAS high and A10 high. Auto-refresh is RAS, CAS and the selected CS low, with WE high and A10 low. Clock enables stay high.
- R2: In every normal precharge-all or auto-refresh cycle, exactly one `csN` bit is low. The sequence always visits every chip select.
- R3: In sleep with `selfRefEn` high, the block requests the bus. After the grant it issues the two staggered precharge-all commands, then one cycle in which all `csN` bits, RAS and CAS are low, WE is high and every `cke` bit is low. From then on `cke` stays low and `csN` stays all high while `sleepReq` remains high.
- R4: `busy` is high from the first command cycle. It stays high for exactly `recBaseCfg + recExtCfg` cycles after the last auto-refresh cycle, with no command issued, then drops. A sum of zero and a base of 10 are both supported.
- R5: With `arbIdle` high, one refresh becomes owed every `intervalCfg` cycles. `refReq` rises while any refresh is owed and the block is idle. Successive request rises are `intervalCfg` cycles apart.
- R6: While `arbIdle` is low, `refReq` stays low until the owed count reaches `postLimitCfg`. At that point `refReq` rises even though `arbIdle` is still low.
- R7: The owed count never exceeds `postLimitCfg`. Once it is saturated, later intervals are lost. With `arbIdle` high, exactly `postLimitCfg` sequences are then granted back to back, with `refReq` high again in the idle cycle between them and low after the last.
- R8: With `sleepReq` high and `selfRefEn` low, `refReq` stays low, no command is driven, `cke` stays high and `busy` stays low.
- R9: After `sleepReq` falls in self-refresh, `cke` is high from the next cycle. `busy` stays high with no command for `exitDelayCfg` cycles, then drops. A delay of zero returns to idle at once.
- R10: A change of a configuration input while `busy` is high has no effect on the sequence in progress. The new value applies from the next sequence.
- R11: During and right after reset, `busy` and `refReq` are low, all `csN`, RAS, CAS and WE are high, A10 is low and all `cke` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intervalCfg | input | INT_W | Refresh interval in cycles |
| postLimitCfg | input | POST_W | Maximum number of owed refreshes |
| recBaseCfg | input | REC_W | Base recovery count |
| recExtCfg | input | REC_W | Extension recovery count |
| exitDelayCfg | input | EXIT_W | Cycles to wait after self-refresh exit |
| selfRefEn | input | 1 | In sleep, select self-refresh (1) or no refresh (0) |
| sleepReq | input | 1 | Sleep mode request |
| arbIdle | input | 1 | Arbiter has no traffic pending |
| refGnt | input | 1 | Arbiter grants the bus to the sequencer |
| refReq | output | 1 | Sequencer asks the arbiter for the bus |
| busy | output | 1 | Sequence, recovery or self-refresh in progress |
| csN | output | NUM_CS | Chip selects, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10 (all-bank precharge) |
| cke | output | NUM_CS | Clock enables per chip select |

## Verification
The command pins are decoded directly from the registered sequence state. The first command is therefore due in the cycle right after the edge that samples the grant, and each later command one cycle after the one before. `busy` falls in the cycle after exactly `recBaseCfg + recExtCfg` recovery cycles, or `exitDelayCfg` cycles after a self-refresh exit. `refReq` is a combinational function of state, owed count and arbiter idle. The bench therefore drives every input and samples every output on the falling clock edge, and it counts falling edges from the grant to place each comparison in its due cycle. Gaps between request rises are measured against the bench's own cycle counter, to check the interval and the posting limit.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_REF,
    ST_REC,
    ST_SRPRE,
    ST_SRENT,
    ST_SRHOLD,
    ST_SREXIT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic startNorm;
    logic clearOwed;
    logic freezeInt;
    logic slotClr;
    logic slotInc;
    logic loadRec;
    logic loadExit;
    logic waitDec;
    logic cmdPre;
    logic cmdRef;
    logic cmdSrEnt;
    logic ckeOff;
  } seqStrobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic slotLast;
    logic waitLast;
    logic recZero;
    logic exitZero;
    logic owedNz;
    logic owedFull;
  } seqStatus_t;

endpackage

// File: rtl/dram_refresh_dp.sv
module dram_refresh_dp
  import dram_refresh_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int INT_W  = 16,
  parameter int POST_W = 4,
  parameter int REC_W  = 8,
  parameter int EXIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  output seqStatus_t        stat,
  input  logic [INT_W-1:0]  intervalCfg,
  input  logic [POST_W-1:0] postLimitCfg,
  input  logic [REC_W-1:0]  recBaseCfg,
  input  logic [REC_W-1:0]  recExtCfg,
  input  logic [EXIT_W-1:0] exitDelayCfg,
  output logic [NUM_CS-1:0] csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              a10,
  output logic [NUM_CS-1:0] cke
);

  localparam int SLOT_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int WAIT_W = (REC_W + 1 > EXIT_W) ? REC_W + 1 : EXIT_W;

  logic [INT_W-1:0]  intervalQ;
  logic [POST_W-1:0] postLimQ;
  logic [REC_W-1:0]  recBaseQ;
  logic [REC_W-1:0]  recExtQ;
  logic [EXIT_W-1:0] exitDlyQ;
  logic [INT_W-1:0]  intCnt;
  logic [POST_W-1:0] owed;
  logic [SLOT_W-1:0] slot;
  logic [WAIT_W-1:0] waitCnt;
  logic              tick;
  logic              incOwed;
  logic              decOwed;

  // configuration is captured only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalQ <= '0;
      postLimQ  <= '0;
      recBaseQ  <= '0;
      recExtQ   <= '0;
      exitDlyQ  <= '0;
    end else if (strb.latchCfg) begin
      intervalQ <= intervalCfg;
      postLimQ  <= postLimitCfg;
      recBaseQ  <= recBaseCfg;
      recExtQ   <= recExtCfg;
      exitDlyQ  <= exitDelayCfg;
    end
  end

  assign tick    = !strb.freezeInt && (intCnt == INT_W'(1));
  assign incOwed = tick && (owed < postLimQ);
  assign decOwed = strb.startNorm && (owed != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt <= '0;
      owed   <= '0;
    end else begin
      if (!strb.freezeInt)
        intCnt <= (intCnt <= INT_W'(1)) ? intervalQ : intCnt - INT_W'(1);
      if (strb.clearOwed) owed <= '0;
      else                owed <= owed + POST_W'(incOwed) - POST_W'(decOwed);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot    <= '0;
      waitCnt <= '0;
    end else begin
      if (strb.slotClr)      slot <= '0;
      else if (strb.slotInc) slot <= slot + SLOT_W'(1);
      if (strb.loadRec)       waitCnt <= WAIT_W'(recBaseQ) + WAIT_W'(recExtQ);
      else if (strb.loadExit) waitCnt <= WAIT_W'(exitDlyQ);
      else if (strb.waitDec)  waitCnt <= waitCnt - WAIT_W'(1);
    end
  end

  assign stat.slotLast = (slot == SLOT_W'(NUM_CS - 1));
  assign stat.waitLast = (waitCnt == WAIT_W'(1));
  assign stat.recZero  = (recBaseQ == '0) && (recExtQ == '0);
  assign stat.exitZero = (exitDlyQ == '0);
  assign stat.owedNz   = (owed != '0);
  assign stat.owedFull = (owed != '0) && (owed >= postLimQ);

  // per chip-select pin decode
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = ~(((strb.cmdPre || strb.cmdRef) && (slot == SLOT_W'(i))) || strb.cmdSrEnt);
    assign cke[i] = ~strb.ckeOff;
  end

  assign rasN = ~(strb.cmdPre || strb.cmdRef || strb.cmdSrEnt);
  assign casN = ~(strb.cmdRef || strb.cmdSrEnt);
  assign weN  = ~strb.cmdPre;
  assign a10  = strb.cmdPre;

  // R2: one chip select per staggered command
  a_r2_single_cs: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdPre || strb.cmdRef) |-> ($countones(~csN) == 1));

  // R3: self-refresh entry reaches every chip select with clock enable low
  a_r3_all_cs: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdSrEnt |-> (csN == '0 && cke == '0));

  // R4: wait counter never underflows while counting
  a_r4_wait_live: assert property (@(posedge clk) disable iff (!rstN)
    strb.waitDec |-> (waitCnt != '0));

  // R7: a saturated owed count does not grow
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (owed >= postLimQ) |=> (owed <= $past(owed)));

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       selfRefEn,
  input  logic       arbIdle,
  input  logic       refGnt,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       refReq,
  output logic       busy
);

  seqState_t state, stateNxt;
  logic idle, srPath, start, inSr;

  assign idle   = (state == ST_IDLE);
  assign srPath = sleepReq && selfRefEn;
  assign inSr   = (state == ST_SRPRE) || (state == ST_SRENT) ||
                  (state == ST_SRHOLD) || (state == ST_SREXIT);
  assign refReq = idle && (srPath ||
                  (!sleepReq && stat.owedNz && (arbIdle || stat.owedFull)));
  assign start  = refReq && refGnt;
  assign busy   = !idle;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (start) stateNxt = srPath ? ST_SRPRE : ST_PRE;
      ST_PRE:    if (stat.slotLast) stateNxt = ST_REF;
      ST_REF:    if (stat.slotLast) stateNxt = stat.recZero ? ST_IDLE : ST_REC;
      ST_REC:    if (stat.waitLast) stateNxt = ST_IDLE;
      ST_SRPRE:  if (stat.slotLast) stateNxt = ST_SRENT;
      ST_SRENT:  stateNxt = ST_SRHOLD;
      ST_SRHOLD: if (!sleepReq) stateNxt = stat.exitZero ? ST_IDLE : ST_SREXIT;
      ST_SREXIT: if (stat.waitLast) stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb           = '0;
    strb.latchCfg  = idle;
    strb.startNorm = start && !srPath;
    strb.clearOwed = (state == ST_SRENT);
    strb.freezeInt = (idle && sleepReq && !selfRefEn) || inSr;
    strb.slotClr   = idle || ((state == ST_PRE) && stat.slotLast);
    strb.slotInc   = ((state == ST_PRE) || (state == ST_REF) || (state == ST_SRPRE))
                     && !stat.slotLast;
    strb.loadRec   = (state == ST_REF) && stat.slotLast;
    strb.loadExit  = (state == ST_SRHOLD) && !sleepReq;
    strb.waitDec   = (state == ST_REC) || (state == ST_SREXIT);
    strb.cmdPre    = (state == ST_PRE) || (state == ST_SRPRE);
    strb.cmdRef    = (state == ST_REF);
    strb.cmdSrEnt  = (state == ST_SRENT);
    strb.ckeOff    = (state == ST_SRENT) || (state == ST_SRHOLD);
  end

  // R1: precharge phase hands over to refresh phase directly
  a_r1_pre_to_ref: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE && stat.slotLast) |=> (state == ST_REF));

  // R3: single all-select refresh only after staggered precharges
  a_r3_srent_after_pre: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SRENT) |-> ($past(state) == ST_SRPRE));

  // R4: recovery keeps busy until its count runs out
  a_r4_busy_in_rec: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REC && !stat.waitLast) |=> busy);

  // R8: sleep without self-refresh never asks for the bus
  a_r8_no_req_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !selfRefEn) |-> !refReq);

  // R9: self-refresh is held while sleep is requested
  a_r9_hold_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SRHOLD && sleepReq) |=> (state == ST_SRHOLD));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int INT_W  = 16,
  parameter int POST_W = 4,
  parameter int REC_W  = 8,
  parameter int EXIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INT_W-1:0]  intervalCfg,
  input  logic [POST_W-1:0] postLimitCfg,
  input  logic [REC_W-1:0]  recBaseCfg,
  input  logic [REC_W-1:0]  recExtCfg,
  input  logic [EXIT_W-1:0] exitDelayCfg,
  input  logic              selfRefEn,
  input  logic              sleepReq,
  input  logic              arbIdle,
  input  logic              refGnt,
  output logic              refReq,
  output logic              busy,
  output logic [NUM_CS-1:0] csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              a10,
  output logic [NUM_CS-1:0] cke
);

  seqStrobe_t strb;
  seqStatus_t stat;

  dram_refresh_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .selfRefEn (selfRefEn),
    .arbIdle   (arbIdle),
    .refGnt    (refGnt),
    .stat      (stat),
    .strb      (strb),
    .refReq    (refReq),
    .busy      (busy)
  );

  dram_refresh_dp #(
    .NUM_CS (NUM_CS),
    .INT_W  (INT_W),
    .POST_W (POST_W),
    .REC_W  (REC_W),
    .EXIT_W (EXIT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .stat         (stat),
    .intervalCfg  (intervalCfg),
    .postLimitCfg (postLimitCfg),
    .recBaseCfg   (recBaseCfg),
    .recExtCfg    (recExtCfg),
    .exitDelayCfg (exitDelayCfg),
    .csN          (csN),
    .rasN         (rasN),
    .casN         (casN),
    .weN          (weN),
    .a10          (a10),
    .cke          (cke)
  );

endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic [15:0] intervalCfg;
  logic [3:0]  postLimitCfg;
  logic [7:0]  recBaseCfg, recExtCfg, exitDelayCfg;
  logic        selfRefEn, sleepReq, arbIdle, refGnt;
  logic        refReq, busy, rasN, casN, weN, a10;
  logic [1:0]  csN, cke;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  dram_refresh_sched uut (
    .clk(clk), .rstN(rstN), .intervalCfg(intervalCfg), .postLimitCfg(postLimitCfg),
    .recBaseCfg(recBaseCfg), .recExtCfg(recExtCfg), .exitDelayCfg(exitDelayCfg),
    .selfRefEn(selfRefEn), .sleepReq(sleepReq), .arbIdle(arbIdle), .refGnt(refGnt),
    .refReq(refReq), .busy(busy), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .a10(a10), .cke(cke)
  );

  wire [7:0] pinsNow = {csN, rasN, casN, weN, a10, cke};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 0 idle, 1 precharge-all, 2 auto-refresh, 3 self-refresh entry, 4 self-refresh hold
  function automatic logic [7:0] expPins(input int phase, input int slot);
    logic [1:0] sel;
    sel = ~(2'b01 << slot);
    case (phase)
      1:       return {sel, 4'b0101, 2'b11};
      2:       return {sel, 4'b0010, 2'b11};
      3:       return {2'b00, 4'b0010, 2'b00};
      4:       return {2'b11, 4'b1110, 2'b00};
      default: return {2'b11, 4'b1110, 2'b11};
    endcase
  endfunction

  task automatic waitReq(input int maxCyc, output bit got, output int riseAt);
    got = 0;
    riseAt = cyc;
    for (int i = 0; i < maxCyc; i++) begin
      if (refReq) begin
        got = 1;
        riseAt = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic runNormal(input int dly, input int expRec, input bit swapCfg,
                           input logic [7:0] swapVal, output int riseAt);
    bit got;
    waitReq(600, got, riseAt);
    chk(got, "R5", "request seen", got, 1);
    if (!got) return;
    repeat (dly) @(negedge clk);
    refGnt = 1'b1;
    @(negedge clk);
    refGnt = 1'b0;
    if (swapCfg) recBaseCfg = swapVal;  // R10: change while busy
    for (int s = 0; s < 2; s++) begin
      if (s > 0) @(negedge clk);
      chk(pinsNow == expPins(1, s), "R1", "precharge-all pins", pinsNow, expPins(1, s));
      chk($countones(~csN) == 1, "R2", "one cs in precharge", csN, 0);
      chk(busy == 1'b1, "R4", "busy during commands", busy, 1);
    end
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      chk(pinsNow == expPins(2, s), "R1", "auto-refresh pins", pinsNow, expPins(2, s));
      chk($countones(~csN) == 1, "R2", "one cs in refresh", csN, 0);
    end
    for (int j = 0; j < expRec; j++) begin
      @(negedge clk);
      chk(busy == 1'b1, "R4", "busy in recovery", busy, 1);
      chk(pinsNow == expPins(0, 0), "R4", "quiet in recovery", pinsNow, expPins(0, 0));
    end
    @(negedge clk);
    chk(busy == 1'b0, "R4", "busy released", busy, 0);
  endtask

  initial begin
    int r1, r2, startC, b, e, d;
    bit got;
    void'($urandom(32'd1234));
    rstN = 1'b0;
    intervalCfg = 16'd40; postLimitCfg = 4'd4;
    recBaseCfg = 8'd3; recExtCfg = 8'd2; exitDelayCfg = 8'd5;
    selfRefEn = 1'b0; sleepReq = 1'b0; arbIdle = 1'b1; refGnt = 1'b0;

    repeat (3) @(negedge clk);
    chk(pinsNow == expPins(0, 0), "R11", "pins in reset", pinsNow, expPins(0, 0));
    chk(busy == 1'b0 && refReq == 1'b0, "R11", "busy/req in reset", {busy, refReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(pinsNow == expPins(0, 0), "R11", "pins after reset", pinsNow, expPins(0, 0));
    chk(busy == 1'b0 && refReq == 1'b0, "R11", "busy/req after reset", {busy, refReq}, 0);

    // normal sequence and interval spacing
    runNormal(0, 5, 1'b0, 8'd0, r1);
    chk(refReq == 1'b0, "R5", "no request once drained", refReq, 0);
    runNormal(2, 5, 1'b0, 8'd0, r2);
    chk(r2 - r1 == 40, "R5", "interval between requests", r2 - r1, 40);

    // base of ten, then zero recovery
    recBaseCfg = 8'd10; recExtCfg = 8'd0;
    runNormal(0, 10, 1'b0, 8'd0, r1);
    recBaseCfg = 8'd0;
    runNormal(1, 0, 1'b0, 8'd0, r1);

    // R10: config change while busy applies to the next sequence only
    recBaseCfg = 8'd4; recExtCfg = 8'd1;
    runNormal(0, 5, 1'b1, 8'd12, r1);
    runNormal(0, 13, 1'b0, 8'd0, r1);

    // random recovery values and grant delays
    for (int k = 0; k < 30; k++) begin
      b = $urandom % 16; e = $urandom % 8; d = $urandom % 3;
      recBaseCfg = 8'(b); recExtCfg = 8'(e);
      runNormal(d, b + e, 1'b0, 8'd0, r1);
    end

    // R6 posting and R7 saturation
    recBaseCfg = 8'd2; recExtCfg = 8'd1;
    intervalCfg = 16'd100; postLimitCfg = 4'd3; arbIdle = 1'b0;
    startC = cyc;
    waitReq(1000, got, r1);
    chk(got && arbIdle == 1'b0, "R6", "request at limit with arbiter busy", got, 1);
    chk((r1 - startC) >= 200 && (r1 - startC) <= 245, "R6", "deferred until limit",
        r1 - startC, 200);
    repeat (205) @(negedge clk);
    arbIdle = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      runNormal(0, 3, 1'b0, 8'd0, r1);
      chk(refReq == (k < 3), "R7", "owed count drains at limit", refReq, (k < 3));
    end

    // R8 sleep without self-refresh
    intervalCfg = 16'd40; postLimitCfg = 4'd4;
    selfRefEn = 1'b0; sleepReq = 1'b1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (i % 10 == 0) begin
        chk(refReq == 1'b0 && busy == 1'b0, "R8", "no request in sleep", {refReq, busy}, 0);
        chk(pinsNow == expPins(0, 0), "R8", "no command in sleep", pinsNow, expPins(0, 0));
      end
    end
    sleepReq = 1'b0;
    @(negedge clk);

    // R3 / R9 self-refresh with exit delay 5, then exit delay 0
    for (int pass = 0; pass < 2; pass++) begin
      exitDelayCfg = (pass == 0) ? 8'd5 : 8'd0;
      while (busy) @(negedge clk);
      selfRefEn = 1'b1; sleepReq = 1'b1;
      @(negedge clk);
      chk(refReq == 1'b1, "R3", "sleep entry request", refReq, 1);
      refGnt = 1'b1;
      @(negedge clk);
      refGnt = 1'b0;
      chk(pinsNow == expPins(1, 0), "R3", "entry precharge cs0", pinsNow, expPins(1, 0));
      @(negedge clk);
      chk(pinsNow == expPins(1, 1), "R3", "entry precharge cs1", pinsNow, expPins(1, 1));
      @(negedge clk);
      chk(pinsNow == expPins(3, 0), "R3", "single refresh all cs", pinsNow, expPins(3, 0));
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk(pinsNow == expPins(4, 0), "R3", "cke held low", pinsNow, expPins(4, 0));
      end
      sleepReq = 1'b0;
      for (int j = 0; j < ((pass == 0) ? 5 : 0); j++) begin
        @(negedge clk);
        chk(pinsNow == expPins(0, 0), "R9", "cke high no command", pinsNow, expPins(0, 0));
        chk(busy == 1'b1, "R9", "busy during exit delay", busy, 1);
      end
      @(negedge clk);
      chk(busy == 1'b0 && cke == 2'b11, "R9", "exit complete", {busy, cke}, 2'b011);
      selfRefEn = 1'b0;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule